// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in an Ethernet receive path and decides, frame by frame, whether a frame is kept. The receive datapath hands it the six destination-address bytes of each frame, in wire order, over a byte stream whose first beat carries a start flag. From those bytes the block works out what kind of address the frame carries. It then produces an accept bit and a two-bit destination class, which the receive status word carries onward.

Software-side logic sets up the filter through two plain write ports. One writes a 32-bit control word, which holds the accept enables and a small word pointer. The other writes a 16-bit data word into the station-address slot that the pointer selects. The control enables and the station address in force for a frame are sampled when that frame's first byte is taken. A frame already in progress therefore never sees a change made during it.

The byte stream uses valid/ready. `s_ready` is held high at all times, so the block never applies back-pressure, and a byte counts on every cycle in which `s_valid` is high. Beats with `s_valid` low are gaps and may appear anywhere. Bytes after the sixth, up to the next start beat, are ignored.

Top module: `rx_dest_filter`

## Requirements
- R1: Out of reset `dec_valid`, `dec_accept` and `dec_class` are all 0 and `s_ready` is 1.
- R2: A destination of all ones is a broadcast. With the filter enabled (control bit 31) and accept-broadcast (bit 30) set, it is accepted with class 3. With bit 30 clear, it is rejected with class 0.
- R3: A non-broadcast destination whose first byte has bit 0 set is a multicast. It is accepted with class 2 when accept-multicast (bit 29) is set, and rejected with class 0 otherwise.
- R4: Any other destination is a unicast. With accept-unicast (bit 28) set, it is accepted with class 1 whatever the station address holds.
- R5: With bit 28 clear and perfect-match (bit 27) set, a unicast is accepted with class 1 only when all six bytes equal the station address. A mismatch in any single byte rejects it with class 0.
- R6: With bit 31 clear, every frame is rejected with class 0, whatever the other bits hold.
- R7: Control bits 9:0 form a word pointer. A data write stores its bits 7:0 as station byte p and its bits 15:8 as station byte p+1, for pointer p of 0, 2 or 4. Byte 0 is the first byte on the wire. A data write with any other pointer value changes nothing.
- R8: `dec_valid` rises in the cycle after the sixth accepted byte. Cycles with `s_valid` low are not counted. The decision then holds steady until the next start beat (`s_valid` and `s_first`), and that beat clears `dec_valid`, `dec_accept` and `dec_class` to 0.
- R9: The control word and station address used for a frame are the ones in force when the frame's start beat is taken. Writes made during the frame take effect from the next frame.
- R10: Control bits 21, 20 and 26:23 have no effect on the decision.
- R11: Bytes that arrive after the sixth and before the next start beat leave the decision unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctl_we | input | 1 | Write strobe for the control word |
| cfg_ctl_wdata | input | 32 | Control word: enables in bits 31:27, word pointer in bits 9:0 |
| cfg_dat_we | input | 1 | Write strobe for a station-address word |
| cfg_dat_wdata | input | 16 | Station-address word for the slot the pointer selects |
| s_valid | input | 1 | Destination byte present |
| s_ready | output | 1 | Always 1: the block never stalls the stream |
| s_first | input | 1 | Marks the first destination byte of a frame |
| s_data | input | 8 | Destination byte |
| dec_valid | output | 1 | Decision for the current frame is available |
| dec_accept | output | 1 | Frame is accepted |
| dec_class | output | 2 | 0 reject, 1 unicast, 2 multicast, 3 broadcast |

## Verification
The assertions assume two things about the upstream datapath. First, every frame opens with a beat that has both `s_valid` and `s_first` set. Second, `s_first` carries no meaning on cycles when `s_valid` is low. The byte-count and hold properties rely on both assumptions. The directed stimulus keeps within them: it raises `s_first` only on a frame's opening byte and always together with `s_valid`. It lowers `s_first` whenever the stream goes idle, and it issues configuration writes only while the stream is idle or between bytes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    DC_REJECT = 2'd0,
    DC_UNI    = 2'd1,
    DC_MULTI  = 2'd2,
    DC_BCAST  = 2'd3
  } dclass_e;

  localparam int CTL_W      = 32;
  localparam int BIT_FLT_EN = 31;
  localparam int BIT_ACC_BC = 30;
  localparam int BIT_ACC_MC = 29;
  localparam int BIT_ACC_UC = 28;
  localparam int BIT_ACC_PM = 27;
  localparam int PTR_W      = 10;

  typedef struct packed {
    logic en;
    logic bc;
    logic mc;
    logic uc;
    logic pm;
  } acc_flags_t;

endpackage

// File: rtl/rxf_station_regs.sv
module rxf_station_regs
  import rxf_pkg::*;
#(
  parameter int NBYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_we,
  input  logic [CTL_W-1:0]      ctl_wdata,
  input  logic                  dat_we,
  input  logic [15:0]           dat_wdata,
  output acc_flags_t            flags,
  output logic [NBYTES*8-1:0]   station
);
  localparam int NWORDS = (NBYTES + 1) / 2;

  logic [PTR_W-1:0] ptr_q;
  acc_flags_t       flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      flags_q <= '0;
    end else if (ctl_we) begin
      ptr_q      <= ctl_wdata[PTR_W-1:0];
      flags_q.en <= ctl_wdata[BIT_FLT_EN];
      flags_q.bc <= ctl_wdata[BIT_ACC_BC];
      flags_q.mc <= ctl_wdata[BIT_ACC_MC];
      flags_q.uc <= ctl_wdata[BIT_ACC_UC];
      flags_q.pm <= ctl_wdata[BIT_ACC_PM];
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic hit;
    assign hit = dat_we && (ptr_q == PTR_W'(2 * w));

    always_ff @(posedge clk) begin
      if (!rst_n) station[(2*w)*8 +: 8] <= '0;
      else if (hit) station[(2*w)*8 +: 8] <= dat_wdata[7:0];
    end

    if (2 * w + 1 < NBYTES) begin : g_hi
      always_ff @(posedge clk) begin
        if (!rst_n) station[(2*w+1)*8 +: 8] <= '0;
        else if (hit) station[(2*w+1)*8 +: 8] <= dat_wdata[15:8];
      end
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/rxf_addr_scan.sv
module rxf_addr_scan
  import rxf_pkg::*;
#(
  parameter int NBYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  beat,
  input  logic                  first,
  input  logic [7:0]            byte_in,
  input  logic [NBYTES*8-1:0]   station_live,
  input  acc_flags_t            flags_live,
  output logic                  last_beat,
  output logic                  is_bcast,
  output logic                  is_group,
  output logic                  is_match,
  output acc_flags_t            flags_frame
);
  localparam int IDX_W = $clog2(NBYTES + 1);

  logic [IDX_W-1:0]        idx_q;
  logic                    busy_q;
  logic                    ones_q;
  logic                    grp_q;
  logic                    match_q;
  logic [NBYTES*8-1:0]     snap_q;
  acc_flags_t              flags_q;
  logic [7:0]              exp_byte;

  assign exp_byte = snap_q[idx_q*8 +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      busy_q  <= 1'b0;
      ones_q  <= 1'b0;
      grp_q   <= 1'b0;
      match_q <= 1'b0;
      snap_q  <= '0;
      flags_q <= '0;
    end else if (beat && first) begin
      idx_q   <= IDX_W'(1);
      busy_q  <= (NBYTES > 1);
      ones_q  <= (byte_in == 8'hFF);
      grp_q   <= byte_in[0];
      match_q <= (byte_in == station_live[7:0]);
      snap_q  <= station_live;
      flags_q <= flags_live;
    end else if (beat && busy_q) begin
      ones_q  <= ones_q & (byte_in == 8'hFF);
      match_q <= match_q & (byte_in == exp_byte);
      idx_q   <= idx_q + IDX_W'(1);
      if (idx_q == IDX_W'(NBYTES - 1)) busy_q <= 1'b0;
    end
  end

  assign last_beat   = beat && !first && busy_q && (idx_q == IDX_W'(NBYTES - 1));
  assign is_bcast    = ones_q & (byte_in == 8'hFF);
  assign is_match    = match_q & (byte_in == exp_byte);
  assign is_group    = grp_q;
  assign flags_frame = flags_q;
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
(
  input  acc_flags_t flags,
  input  logic       is_bcast,
  input  logic       is_group,
  input  logic       is_match,
  output logic       accept,
  output dclass_e    dclass
);
  dclass_e kind;

  always_comb begin
    if (is_bcast) begin
      kind   = DC_BCAST;
      accept = flags.en & flags.bc;
    end else if (is_group) begin
      kind   = DC_MULTI;
      accept = flags.en & flags.mc;
    end else begin
      kind   = DC_UNI;
      accept = flags.en & (flags.uc | (flags.pm & is_match));
    end
    dclass = accept ? kind : DC_REJECT;
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int NBYTES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_ctl_we,
  input  logic [31:0] cfg_ctl_wdata,
  input  logic        cfg_dat_we,
  input  logic [15:0] cfg_dat_wdata,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic        s_first,
  input  logic [7:0]  s_data,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic [1:0]  dec_class
);
  acc_flags_t            flags_live;
  acc_flags_t            flags_frame;
  logic [NBYTES*8-1:0]   station_live;
  logic                  beat;
  logic                  last_beat;
  logic                  is_bcast;
  logic                  is_group;
  logic                  is_match;
  logic                  acc_nx;
  dclass_e               cls_nx;

  assign s_ready = 1'b1;
  assign beat    = s_valid & s_ready;

  rxf_station_regs #(.NBYTES(NBYTES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (cfg_ctl_we),
    .ctl_wdata (cfg_ctl_wdata),
    .dat_we    (cfg_dat_we),
    .dat_wdata (cfg_dat_wdata),
    .flags     (flags_live),
    .station   (station_live)
  );

  rxf_addr_scan #(.NBYTES(NBYTES)) u_scan (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat         (beat),
    .first        (s_first),
    .byte_in      (s_data),
    .station_live (station_live),
    .flags_live   (flags_live),
    .last_beat    (last_beat),
    .is_bcast     (is_bcast),
    .is_group     (is_group),
    .is_match     (is_match),
    .flags_frame  (flags_frame)
  );

  rxf_classify u_cls (
    .flags    (flags_frame),
    .is_bcast (is_bcast),
    .is_group (is_group),
    .is_match (is_match),
    .accept   (acc_nx),
    .dclass   (cls_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_class  <= 2'd0;
    end else if (beat && s_first) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_class  <= 2'd0;
    end else if (last_beat) begin
      dec_valid  <= 1'b1;
      dec_accept <= acc_nx;
      dec_class  <= cls_nx;
    end
  end
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_ctl_we,
  input logic [31:0] cfg_ctl_wdata,
  input logic        s_valid,
  input logic        s_ready,
  input logic        s_first,
  input logic        dec_valid,
  input logic        dec_accept,
  input logic [1:0]  dec_class
);
  logic       en_cfg_q;
  logic       en_frm_q;
  logic [2:0] cnt_q;
  logic       start;

  assign start = s_valid && s_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_cfg_q <= 1'b0;
      en_frm_q <= 1'b0;
      cnt_q    <= 3'd0;
    end else begin
      if (cfg_ctl_we) en_cfg_q <= cfg_ctl_wdata[31];
      if (start) begin
        en_frm_q <= en_cfg_q;
        cnt_q    <= 3'd1;
      end else if (s_valid && cnt_q != 3'd0 && cnt_q < 3'd6) begin
        cnt_q <= cnt_q + 3'd1;
      end
    end
  end

  a_r11_ready_high: assert property (@(posedge clk) disable iff (!rst_n) s_ready);

  a_r8_rise_after_six: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> (cnt_q == 3'd6));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!dec_valid && dec_class == 2'd0 && !dec_accept));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !start) |=> (dec_valid && $stable(dec_accept) && $stable(dec_class)));

  a_r2_class_tracks_accept: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_accept == (dec_class != 2'd0)));

  a_r6_disabled_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !en_frm_q) |-> (dec_class == 2'd0));
endmodule

bind rx_dest_filter rxf_filter_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_ctl_we    (cfg_ctl_we),
  .cfg_ctl_wdata (cfg_ctl_wdata),
  .s_valid       (s_valid),
  .s_ready       (s_ready),
  .s_first       (s_first),
  .dec_valid     (dec_valid),
  .dec_accept    (dec_accept),
  .dec_class     (dec_class)
);

// File: tb/rx_dest_filter_test.sv
`timescale 1ns/1ps
module rx_dest_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ctl_we = 1'b0;
  logic [31:0] cfg_ctl_wdata = '0;
  logic        cfg_dat_we = 1'b0;
  logic [15:0] cfg_dat_wdata = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        s_first = 1'b0;
  logic [7:0]  s_data = '0;
  logic        dec_valid;
  logic        dec_accept;
  logic [1:0]  dec_class;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [47:0] STA  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] STA2 = 48'h02_11_22_33_66_77;
  localparam logic [47:0] BC   = 48'hFF_FF_FF_FF_FF_FF;

  always #4 clk = ~clk;

  rx_dest_filter uut (.*);

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    s_valid = 1'b0; s_first = 1'b0;
    cfg_ctl_we = 1'b0; cfg_dat_we = 1'b0;
  endtask

  task automatic drive_byte(input logic [7:0] b, input bit first);
    @(negedge clk);
    cfg_ctl_we = 1'b0; cfg_dat_we = 1'b0;
    s_valid = 1'b1; s_first = first; s_data = b;
  endtask

  function automatic logic [7:0] da_byte(input logic [47:0] da, input int i);
    return da[47-8*i -: 8];
  endfunction

  function automatic logic [31:0] ctl(input bit en, bc, mc, uc, pm, input logic [9:0] ptr);
    return {en, bc, mc, uc, pm, 17'd0, ptr};
  endfunction

  task automatic wr_ctl(input logic [31:0] w);
    @(negedge clk);
    s_valid = 1'b0; s_first = 1'b0; cfg_dat_we = 1'b0;
    cfg_ctl_we = 1'b1; cfg_ctl_wdata = w;
  endtask

  task automatic wr_dat(input logic [15:0] w);
    @(negedge clk);
    s_valid = 1'b0; s_first = 1'b0; cfg_ctl_we = 1'b0;
    cfg_dat_we = 1'b1; cfg_dat_wdata = w;
  endtask

  task automatic load_station(input logic [47:0] a, input logic [31:0] flags);
    for (int k = 0; k < 3; k++) begin
      wr_ctl(32'(2 * k));
      wr_dat({da_byte(a, 2*k+1), da_byte(a, 2*k)});
    end
    wr_ctl(flags);
    idle();
  endtask

  task automatic send_frame(input logic [47:0] da);
    for (int i = 0; i < 6; i++) drive_byte(da_byte(da, i), i == 0);
    idle();
  endtask

  task automatic expect_dec(input string req, input int acc, input int cls);
    chk({req, " valid"}, dec_valid, 1);
    chk({req, " accept"}, dec_accept, acc);
    chk({req, " class"}, dec_class, cls);
  endtask

  task automatic t_r1_reset();
    chk("R1 valid", dec_valid, 0);
    chk("R1 accept", dec_accept, 0);
    chk("R1 class", dec_class, 0);
    chk("R1 ready", s_ready, 1);
  endtask

  task automatic t_r2_bcast();
    load_station(STA, ctl(1, 1, 0, 0, 0, 0));
    send_frame(BC);  expect_dec("R2 bcast on", 1, 3);
    wr_ctl(ctl(1, 0, 1, 1, 1, 0)); idle();
    send_frame(BC);  expect_dec("R2 bcast off", 0, 0);
  endtask

  task automatic t_r3_mcast();
    wr_ctl(ctl(1, 0, 1, 0, 0, 0)); idle();
    send_frame(48'h01_00_5E_00_00_01); expect_dec("R3 mcast on", 1, 2);
    wr_ctl(ctl(1, 1, 0, 1, 1, 0)); idle();
    send_frame(48'h01_00_5E_00_00_01); expect_dec("R3 mcast off", 0, 0);
  endtask

  task automatic t_r4_ucast();
    wr_ctl(ctl(1, 0, 0, 1, 0, 0)); idle();
    send_frame(48'h0A_BB_CC_DD_EE_F0); expect_dec("R4 any unicast", 1, 1);
  endtask

  task automatic t_r5_perfect();
    wr_ctl(ctl(1, 0, 0, 0, 1, 0)); idle();
    send_frame(STA); expect_dec("R5 exact", 1, 1);
    send_frame(STA ^ 48'h00_00_00_00_00_01); expect_dec("R5 last byte differs", 0, 0);
    send_frame(STA ^ 48'h04_00_00_00_00_00); expect_dec("R5 first byte differs", 0, 0);
    send_frame(STA ^ 48'h00_00_00_80_00_00); expect_dec("R5 middle byte differs", 0, 0);
  endtask

  task automatic t_r6_disable();
    wr_ctl(ctl(0, 1, 1, 1, 1, 0)); idle();
    send_frame(BC);  expect_dec("R6 bcast disabled", 0, 0);
    send_frame(STA); expect_dec("R6 match disabled", 0, 0);
  endtask

  task automatic t_r7_offsets();
    wr_ctl(ctl(1, 0, 0, 0, 1, 1)); wr_dat(16'hFFFF);
    wr_ctl(ctl(1, 0, 0, 0, 1, 3)); wr_dat(16'hFFFF);
    wr_ctl(ctl(1, 0, 0, 0, 1, 6)); wr_dat(16'hFFFF);
    wr_ctl(ctl(1, 0, 0, 0, 1, 0)); idle();
    send_frame(STA); expect_dec("R7 odd pointer ignored", 1, 1);
    wr_ctl(ctl(1, 0, 0, 0, 1, 4)); wr_dat({da_byte(STA2, 5), da_byte(STA2, 4)});
    wr_ctl(ctl(1, 0, 0, 0, 1, 0)); idle();
    send_frame(STA2); expect_dec("R7 word 4 byte order", 1, 1);
    send_frame(STA);  expect_dec("R7 old address gone", 0, 0);
    load_station(STA, ctl(1, 0, 0, 0, 1, 0));
  endtask

  task automatic t_r8_timing();
    for (int i = 0; i < 5; i++) drive_byte(da_byte(STA, i), i == 0);
    idle();
    chk("R8 not valid after five", dec_valid, 0);
    idle(); idle();
    chk("R8 gaps not counted", dec_valid, 0);
    drive_byte(da_byte(STA, 5), 0);
    idle();
    expect_dec("R8 valid after sixth", 1, 1);
    idle(); idle(); idle();
    expect_dec("R8 held", 1, 1);
    drive_byte(8'h00, 0); drive_byte(8'h13, 0); idle();
    expect_dec("R11 trailing bytes ignored", 1, 1);
    drive_byte(8'hFF, 1); idle();
    chk("R8 start clears valid", dec_valid, 0);
    chk("R8 start clears class", dec_class, 0);
    for (int i = 1; i < 6; i++) drive_byte(8'hFF, 0);
    idle();
    expect_dec("R8 next frame", 0, 0);
  endtask

  task automatic t_r9_midframe();
    for (int i = 0; i < 3; i++) drive_byte(da_byte(STA, i), i == 0);
    wr_ctl(ctl(1, 0, 0, 0, 1, 4));
    wr_dat({da_byte(STA2, 5), da_byte(STA2, 4)});
    wr_ctl(ctl(0, 0, 0, 0, 0, 0));
    for (int i = 3; i < 6; i++) drive_byte(da_byte(STA, i), 0);
    idle();
    expect_dec("R9 frame keeps old setup", 1, 1);
    send_frame(STA); expect_dec("R9 next frame disabled", 0, 0);
    wr_ctl(ctl(1, 0, 0, 0, 1, 0)); idle();
    send_frame(STA2); expect_dec("R9 new address in force", 1, 1);
    load_station(STA, ctl(1, 0, 0, 0, 1, 0));
  endtask

  task automatic t_r10_ignored();
    wr_ctl(ctl(1, 0, 0, 0, 1, 0) | 32'h07B0_0000); idle();
    send_frame(48'h0A_00_00_00_00_01); expect_dec("R10 extra bits no accept", 0, 0);
    send_frame(48'h01_00_00_00_00_01); expect_dec("R10 extra bits no mcast", 0, 0);
    send_frame(STA); expect_dec("R10 match still works", 1, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_r1_reset();
    rst_n = 1'b1;
    idle();
    t_r1_reset();
    t_r2_bcast();
    t_r3_mcast();
    t_r4_ucast();
    t_r5_perfect();
    t_r6_disable();
    t_r7_offsets();
    t_r8_timing();
    t_r9_midframe();
    t_r10_ignored();
    idle();
    finish_run();
  end
endmodule